// File: doc/BRIEF.md
# Audio Sample FIFO with Coded Attention Threshold

This block is a sixteen-entry, 32-bit sample buffer that sits between a serial audio shifter and a DMA or bus engine. The same hardware serves either direction, picked by a static mode input. In receive mode the shifter pushes samples and software drains them. In transmit mode software fills the buffer and the shifter pops it. The reported level follows the direction: filled slots for receive and free slots for transmit. In both cases a larger number means more work for the software side.

A two-bit code picks the attention threshold from a small non-linear set. An attention flag rises whenever the reported level reaches that threshold. A write-one clear input empties the buffer in one cycle. An error flag records the fault that matters in the current direction: overrun in receive mode and underrun in transmit mode. It stays set until it is explicitly cleared. Attention and error each have an enable that routes them onto a single interrupt line. All status outputs and the read data are registered.

Top module: `audio_sample_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the buffer empties and `pop_data`, `level`, `atn_flag`, `err_flag` and `irq` become 0. From the first edge after reset, the status outputs reflect the buffer state.
- R2: Words leave in the order they were accepted. `pop_data` changes only at an edge where `pop` is high and `fifo_clr` is low, and it holds its value otherwise.
- R3: A `push` while 16 words are held and `pop` is low drops the word and leaves the contents unchanged. In receive mode (`tx_mode`=0) this sets the error flag.
- R4: A `pop` while empty returns 0 on `pop_data` after that edge. In transmit mode (`tx_mode`=1) this sets the error flag.
- R5: `level` is the number of held words when `tx_mode`=0, and 16 minus that number when `tx_mode`=1. It reflects the state after the same edge.
- R6: `atn_code` selects a threshold of 1 slot for code 0, 4 for code 1, 8 for code 2 and 12 for code 3. `atn_flag` is 1 exactly when the updated `level` is at least that threshold.
- R7: A push and a pop at the same edge on a non-empty buffer leave the count unchanged, including when it is full.
- R8: `fifo_clr` empties the buffer and takes priority over `push` and `pop` at the same edge. It raises no error, leaves `pop_data` unchanged and does not clear the error flag.
- R9: The error flag is sticky. `err_clr`=1 clears it at the next edge, but an error event at that same edge keeps it set.
- R10: `irq` is 1 exactly when (`atn_flag` and `atn_irq_en`) or (`err_flag` and `err_irq_en`), using the enables sampled at the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 0 = receive direction, 1 = transmit direction |
| push | input | 1 | Write strobe |
| push_data | input | 32 | Sample to write |
| pop | input | 1 | Read strobe |
| pop_data | output | 32 | Registered read sample, or 0 after an underrun |
| atn_code | input | 2 | Attention threshold code |
| fifo_clr | input | 1 | Empty the buffer |
| err_clr | input | 1 | Write-one clear of the error flag |
| atn_irq_en | input | 1 | Route attention to the interrupt |
| err_irq_en | input | 1 | Route the error to the interrupt |
| level | output | 5 | Filled (receive) or free (transmit) slot count |
| atn_flag | output | 1 | Attention threshold reached |
| err_flag | output | 1 | Sticky overrun/underrun flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A wrong pointer or count shows up at the ports one edge later. `level` shifts by the error, the attention flag may flip at a threshold boundary, and the next popped word is either a stale entry or out of order. The bench models the buffer as a queue and compares every registered output after every edge, so a fault is caught on the cycle it first becomes visible. Stuck or lost error bits are exposed by pops on an empty buffer and pushes into a full one in both directions, followed by clears with and without a coincident event.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Attention threshold in slots for each two-bit code.
  function automatic int unsigned atn_slots(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/afifo_ram.sv
module afifo_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          rd_zero,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with synchronous reset, read-first on collision.
  always_ff @(posedge clk) begin
    if (rst || rd_zero) rdata <= '0;
    else if (re)        rdata <= mem[raddr];
  end
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          overrun,
  output logic          underrun
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt == FULL_CNT);
    empty    = (cnt == '0);
    pop_ok   = pop & ~empty;
    push_ok  = push & (~full | pop);
    overrun  = ~clr & push & full & ~pop;
    underrun = ~clr & pop & empty;
    wr_en    = ~clr & push_ok;
    rd_en    = ~clr & pop_ok;
    if (clr)                   cnt_nxt = '0;
    else if (wr_en && !rd_en)  cnt_nxt = cnt + 1'b1;
    else if (rd_en && !wr_en)  cnt_nxt = cnt - 1'b1;
    else                       cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_addr <= '0;
      rd_addr <= '0;
    end else begin
      if (wr_en) wr_addr <= bump(wr_addr);
      if (rd_en) rd_addr <= bump(rd_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/afifo_status.sv
module afifo_status
  import afifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_mode,
  input  logic [1:0]    atn_code,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          overrun,
  input  logic          underrun,
  input  logic          err_clr,
  input  logic          atn_irq_en,
  input  logic          err_irq_en,
  output logic [CW-1:0] level,
  output logic          atn_flag,
  output logic          err_flag,
  output logic          irq
);
  logic [CW-1:0] level_nxt;
  logic          atn_nxt, err_nxt, err_evt;

  always_comb begin
    level_nxt = tx_mode ? (CW'(DEPTH) - cnt_nxt) : cnt_nxt;
    atn_nxt   = 32'(level_nxt) >= atn_slots(atn_code);
    err_evt   = tx_mode ? underrun : overrun;
    err_nxt   = err_evt | (err_flag & ~err_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      atn_flag <= 1'b0;
      err_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      level    <= level_nxt;
      atn_flag <= atn_nxt;
      err_flag <= err_nxt;
      irq      <= (atn_nxt & atn_irq_en) | (err_nxt & err_irq_en);
    end
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  input  logic [1:0]    atn_code,
  input  logic          fifo_clr,
  input  logic          err_clr,
  input  logic          atn_irq_en,
  input  logic          err_irq_en,
  output logic [CW-1:0] level,
  output logic          atn_flag,
  output logic          err_flag,
  output logic          irq
);
  logic          wr_en, rd_en, overrun, underrun;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] fill_cnt, fill_nxt;

  afifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .clr(fifo_clr), .push(push), .pop(pop),
    .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .cnt(fill_cnt), .cnt_nxt(fill_nxt), .overrun(overrun), .underrun(underrun)
  );

  afifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(push_data),
    .re(rd_en), .rd_zero(underrun), .raddr(rd_addr), .rdata(pop_data)
  );

  afifo_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .atn_code(atn_code),
    .cnt_nxt(fill_nxt), .overrun(overrun), .underrun(underrun),
    .err_clr(err_clr), .atn_irq_en(atn_irq_en), .err_irq_en(err_irq_en),
    .level(level), .atn_flag(atn_flag), .err_flag(err_flag), .irq(irq)
  );
endmodule

// File: rtl/audio_sample_fifo_chk.sv
module audio_sample_fifo_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          push,
  input logic          pop,
  input logic          fifo_clr,
  input logic          err_clr,
  input logic          atn_irq_en,
  input logic          err_irq_en,
  input logic [DW-1:0] pop_data,
  input logic [CW-1:0] fill_cnt,
  input logic          atn_flag,
  input logic          err_flag,
  input logic          irq
);
  AST_OVERRUN_DROPS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !fifo_clr && fill_cnt == CW'(DEPTH)) |=> fill_cnt == CW'(DEPTH)); // R3
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop && !fifo_clr && fill_cnt == '0) |=> pop_data == '0); // R4
  AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !fifo_clr && fill_cnt != '0) |=> fill_cnt == $past(fill_cnt)); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> fill_cnt == '0); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag); // R9
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !push && !pop) |=> !err_flag); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((atn_flag && $past(atn_irq_en)) || (err_flag && $past(err_irq_en)))); // R10
endmodule

bind audio_sample_fifo audio_sample_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .fifo_clr(fifo_clr),
  .err_clr(err_clr), .atn_irq_en(atn_irq_en), .err_irq_en(err_irq_en),
  .pop_data(pop_data), .fill_cnt(fill_cnt), .atn_flag(atn_flag),
  .err_flag(err_flag), .irq(irq)
);

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_mode = 1'b0, push = 1'b0, pop = 1'b0;
  logic [31:0] push_data = '0;
  logic [1:0]  atn_code = 2'd0;
  logic        fifo_clr = 1'b0, err_clr = 1'b0, atn_irq_en = 1'b0, err_irq_en = 1'b0;
  logic [31:0] pop_data;
  logic [4:0]  level;
  logic        atn_flag, err_flag, irq;

  audio_sample_fifo i_audio_sample_fifo (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .atn_code(atn_code), .fifo_clr(fifo_clr),
    .err_clr(err_clr), .atn_irq_en(atn_irq_en), .err_irq_en(err_irq_en),
    .level(level), .atn_flag(atn_flag), .err_flag(err_flag), .irq(irq)
  );

  always #5 clk = ~clk;

  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  string       phase = "R1 reset";
  int unsigned q[$];
  logic [31:0] m_pop = '0;
  bit          m_err = 0, m_atn = 0, m_irq = 0;
  int          m_lvl = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2 pop_data", pop_data, m_pop);
    check("R5 level", 32'(level), 32'(m_lvl));
    check("R6 atn_flag", 32'(atn_flag), 32'(m_atn));
    check("R9 err_flag", 32'(err_flag), 32'(m_err));
    check("R10 irq", 32'(irq), 32'(m_irq));
  endtask

  function automatic int slots(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 12;
  endfunction

  // One clock: drive, update the queue model at the edge, compare after it.
  task automatic cyc(input bit p, input logic [31:0] d, input bit o,
                     input bit c = 0, input bit ec = 0);
    int  sz;
    bit  ovr, und;
    push = p; push_data = d; pop = o; fifo_clr = c; err_clr = ec;
    @(posedge clk);
    ovr = 0; und = 0;
    if (c) q.delete();
    else begin
      sz = q.size();
      if (o) begin
        if (sz == 0) begin und = 1; m_pop = '0; end
        else m_pop = q.pop_front();
      end
      if (p) begin
        if (sz == 16 && !o) ovr = 1;
        else q.push_back(d);
      end
    end
    m_err = (tx_mode ? und : ovr) | (m_err & !ec);
    m_lvl = tx_mode ? 16 - q.size() : q.size();
    m_atn = m_lvl >= slots(atn_code);
    m_irq = (m_atn & atn_irq_en) | (m_err & err_irq_en);
    #1;
    compare_all();
  endtask

  task automatic do_reset(input bit tx);
    rst = 1; tx_mode = tx;
    push = 0; pop = 0; fifo_clr = 0; err_clr = 0;
    repeat (2) @(posedge clk);
    #1;
    q.delete(); m_pop = '0; m_err = 0; m_atn = 0; m_irq = 0; m_lvl = 0;
    phase = "R1 reset";
    compare_all();
    rst = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Receive direction
    do_reset(0);
    atn_code = 2'd1; atn_irq_en = 1;
    phase = "R2 order rx";
    for (int i = 0; i < 5; i++) cyc(1, 32'hA000_0000 + i, 0);
    for (int i = 0; i < 2; i++) cyc(0, 0, 1);
    cyc(0, 0, 0);
    phase = "R3 overrun rx";
    for (int i = 0; i < 15; i++) cyc(1, 32'hB000_0000 + i, 0);
    err_irq_en = 1;
    cyc(1, 32'hDEAD_0001, 0);
    cyc(1, 32'hDEAD_0002, 0);
    phase = "R7 full push+pop";
    cyc(1, 32'hC0DE_0001, 1);
    phase = "R9 err clear";
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0);
    phase = "R4 underrun rx";
    for (int i = 0; i < 18; i++) cyc(0, 0, 1);
    phase = "R7 empty push+pop";
    cyc(1, 32'h1234_5678, 1);
    cyc(1, 32'h2222_0000, 1);
    cyc(0, 0, 1);
    phase = "R6 code sweep";
    for (int c = 0; c < 4; c++) begin
      atn_code = 2'(c);
      for (int i = 0; i < 14; i++) cyc(1, 32'h6000_0000 + 32'(c * 16 + i), 0);
      for (int i = 0; i < 14; i++) cyc(0, 0, 1);
    end
    phase = "R8 clear priority";
    for (int i = 0; i < 6; i++) cyc(1, 32'h8000_0000 + i, 0);
    cyc(0, 0, 1);
    cyc(1, 32'h8888_8888, 1, 1);
    cyc(0, 0, 1);
    for (int i = 0; i < 16; i++) cyc(1, 32'h8100_0000 + i, 0);
    cyc(1, 32'h8FFF_FFFF, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0);

    // Transmit direction
    do_reset(1);
    atn_code = 2'd3; atn_irq_en = 0; err_irq_en = 1;
    phase = "R5 tx level";
    cyc(0, 0, 0);
    phase = "R4 underrun tx";
    cyc(0, 0, 1);
    phase = "R9 clear vs event";
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 1);
    phase = "R3 overrun tx";
    atn_irq_en = 1;
    for (int i = 0; i < 17; i++) cyc(1, 32'hE000_0000 + i, 0);
    phase = "R7 tx push+pop";
    for (int i = 0; i < 4; i++) cyc(1, 32'hF000_0000 + i, 1);
    phase = "R8 tx clear";
    cyc(1, 32'h5555_5555, 0, 1);
    phase = "R2 random";
    for (int i = 0; i < 600; i++) begin
      if (i % 150 == 0) atn_code = 2'($urandom_range(0, 3));
      cyc(($urandom_range(0, 99) < 55), $urandom, ($urandom_range(0, 99) < 45),
          ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 5));
    end
    do_reset(0);
    for (int i = 0; i < 400; i++)
      cyc(($urandom_range(0, 99) < 50), $urandom, ($urandom_range(0, 99) < 50),
          ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 5));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule